// File: doc/BRIEF.md
# DRAM Refresh and Access Arbiter

This block shares one dynamic memory array between host read/write cycles and the periodic row refresh that the array needs to keep its contents. An interval timer raises a refresh request at a fixed spacing. The arbiter then hands the array to one owner at a time. The owner is either a refresh cycle, which drives all banks with the current refresh row, or a single host access. All timing comes from nanosecond parameters. These are rounded up to whole clock cycles using a clock-period parameter.

The host pulses a request line. The block answers with a busy level that lasts from acceptance until the full memory cycle time has elapsed. For reads it also gives a one-cycle data-valid pulse. If the host request lands while a refresh is pending or running, the access waits for that refresh to finish and then proceeds. Its latency grows by one refresh duration plus one arbitration cycle. When a refresh and a host request are both waiting at the same moment, refresh always goes first.

Top module: `dram_refresh_arbiter`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, busy, data_valid, arr_host, arr_we, ref_active and every ref_bank_en bit are 0 and ref_row is 0.
- R2: A refresh request is raised every INT_C clock cycles after reset. Each refresh holds ref_active and all ref_bank_en bits high for exactly REF_C consecutive cycles.
- R3: A high host_req is accepted at a clock edge where busy is low, and busy is high from the next cycle. A host_req seen while busy is high is ignored and starts no access.
- R4: For an accepted read (host_we = 0) with no refresh pending, data_valid is a single-cycle pulse seen ACC_C+1 cycles after the accepting edge. A write produces no data_valid pulse.
- R5: For an access that meets no refresh, busy stays high for exactly CYC_C+1 cycles and then drops.
- R6: ref_row advances by one at the end of each refresh and wraps from 127 back to 0 (7-bit row). It does not change at any other time.
- R7: When a refresh request and a host request are both waiting at the arbitration point, the refresh is performed first. The host access follows it, so a read's data_valid arrives REF_C+1 cycles later than in R4.
- R8: During a host access arr_host is high for CYC_C cycles. For a write, arr_we is high in all of them; for a read, it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, sampled when busy is low |
| host_we | input | 1 | 1 = write, 0 = read; captured with the request |
| busy | output | 1 | Host cycle in progress, from acceptance to end of cycle time |
| data_valid | output | 1 | One-cycle pulse when read data is ready |
| arr_host | output | 1 | Array granted to the host access |
| arr_we | output | 1 | Write strobe to the array during a host write |
| ref_active | output | 1 | Refresh cycle occupies the array |
| ref_bank_en | output | BANKS | Per-bank refresh enable, all banks together |
| ref_row | output | ROW_W | Row address being refreshed |

## Verification
A host request and a refresh timer expiry can meet at the same arbitration point, and that collision is what the bench aims at. The bench follows its own model of the interval timer and raises host_req in the very cycle the timer expires. This makes both requests pending together when the arbiter next looks. The outcome is judged by seeing ref_active rise before arr_host, and by the read's data_valid latency being ACC_C+1 plus REF_C+1 cycles. Throughout the run, a cycle-by-cycle reference model also cross-checks every other meeting of host traffic with refresh.

// File: rtl/drfa_pkg.sv
package drfa_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_REFRESH = 2'd1,
        ARB_ACCESS  = 2'd2
    } arb_state_e;

    // round a duration in ns up to whole clock cycles
    function automatic int ns_to_cycles(input int dur_ns, input int period_ns);
        return (dur_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/drfa_interval_timer.sv
module drfa_interval_timer #(
    parameter int INT_C = 1375
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (INT_C > 1) ? $clog2(INT_C) : 1;
    localparam logic [TW-1:0] LAST = TW'(INT_C - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/drfa_row_counter.sv
module drfa_row_counter #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = advance ? row_q + 1'b1 : row_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;
endmodule

// File: rtl/drfa_arbiter_core.sv
module drfa_arbiter_core
    import drfa_pkg::*;
#(
    parameter int ACC_C = 53,
    parameter int CYC_C = 100,
    parameter int REF_C = 68
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic host_we,
    input  logic refresh_tick,
    output logic busy,
    output logic data_valid,
    output logic arr_host,
    output logic arr_we,
    output logic ref_active,
    output logic ref_done
);
    localparam int CNT_MAX = (CYC_C > REF_C) ? CYC_C : REF_C;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_C - 1);
    localparam logic [CNT_W-1:0] CYC_LAST = CNT_W'(CYC_C - 1);
    localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_C - 1);

    typedef struct packed {
        arb_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             ref_pend;
        logic             host_pend;
        logic             we;
        logic             busy;
        logic             dv;
    } arb_regs_t;

    arb_regs_t r_d, r_q;
    logic      accept;

    always_comb begin
        r_d      = r_q;
        r_d.dv   = 1'b0;
        ref_done = 1'b0;
        accept   = host_req && !r_q.busy;

        unique case (r_q.state)
            ARB_IDLE: begin
                // refresh has priority over a waiting host access
                if (r_q.ref_pend) begin
                    r_d.state    = ARB_REFRESH;
                    r_d.cnt      = REF_LAST;
                    r_d.ref_pend = 1'b0;
                end else if (r_q.host_pend) begin
                    r_d.state     = ARB_ACCESS;
                    r_d.cnt       = '0;
                    r_d.host_pend = 1'b0;
                end
            end
            ARB_REFRESH: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ARB_IDLE;
                    ref_done  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ARB_ACCESS: begin
                if (r_q.cnt == ACC_LAST && !r_q.we) r_d.dv = 1'b1;
                if (r_q.cnt == CYC_LAST) begin
                    r_d.state = ARB_IDLE;
                    r_d.busy  = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ARB_IDLE;
        endcase

        if (refresh_tick) r_d.ref_pend = 1'b1;
        if (accept) begin
            r_d.host_pend = 1'b1;
            r_d.busy      = 1'b1;
            r_d.we        = host_we;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= ARB_IDLE;
            r_q.cnt       <= '0;
            r_q.ref_pend  <= 1'b0;
            r_q.host_pend <= 1'b0;
            r_q.we        <= 1'b0;
            r_q.busy      <= 1'b0;
            r_q.dv        <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = r_q.busy;
    assign data_valid = r_q.dv;
    assign arr_host   = (r_q.state == ARB_ACCESS);
    assign arr_we     = (r_q.state == ARB_ACCESS) && r_q.we;
    assign ref_active = (r_q.state == ARB_REFRESH);
endmodule

// File: rtl/dram_refresh_arbiter.sv
module dram_refresh_arbiter
    import drfa_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int ACCESS_NS     = 525,
    parameter int CYCLE_NS      = 1000,
    parameter int REFRESH_NS    = 675,
    parameter int INTERVAL_NS   = 13750,
    parameter int ROW_W         = 7,
    parameter int BANKS         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    output logic             busy,
    output logic             data_valid,
    output logic             arr_host,
    output logic             arr_we,
    output logic             ref_active,
    output logic [BANKS-1:0] ref_bank_en,
    output logic [ROW_W-1:0] ref_row
);
    localparam int ACC_C = ns_to_cycles(ACCESS_NS, CLK_PERIOD_NS);
    localparam int CYC_C = ns_to_cycles(CYCLE_NS, CLK_PERIOD_NS);
    localparam int REF_C = ns_to_cycles(REFRESH_NS, CLK_PERIOD_NS);
    localparam int INT_C = ns_to_cycles(INTERVAL_NS, CLK_PERIOD_NS);

    logic tick;
    logic ref_done;

    drfa_interval_timer #(.INT_C(INT_C)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    drfa_arbiter_core #(
        .ACC_C(ACC_C),
        .CYC_C(CYC_C),
        .REF_C(REF_C)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .refresh_tick(tick),
        .busy        (busy),
        .data_valid  (data_valid),
        .arr_host    (arr_host),
        .arr_we      (arr_we),
        .ref_active  (ref_active),
        .ref_done    (ref_done)
    );

    drfa_row_counter #(.ROW_W(ROW_W)) u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(ref_done),
        .row    (ref_row)
    );

    // all banks are refreshed together
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign ref_bank_en[b] = ref_active;
    end
endmodule

// File: rtl/drfa_checker.sv
module drfa_checker #(
    parameter int REF_C = 68,
    parameter int ROW_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_req,
    input logic             busy,
    input logic             data_valid,
    input logic             ref_active,
    input logic [ROW_W-1:0] ref_row
);
    localparam int RW = $clog2(REF_C + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (ref_active) run_q <= run_q + 1'b1;
        else                 run_q <= '0;
    end

    // R2
    ref_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_active) |-> (run_q == RW'(REF_C)));

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !busy) |=> busy);

    // R4
    dv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R5
    dv_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> busy);

    // R6
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_row) |-> ($fell(ref_active) && ref_row == ROW_W'($past(ref_row) + 1'b1)));
endmodule

bind dram_refresh_arbiter drfa_checker #(.REF_C(REF_C), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .busy      (busy),
    .data_valid(data_valid),
    .ref_active(ref_active),
    .ref_row   (ref_row)
);

// File: tb/dram_refresh_arbiter_tb.sv
module dram_refresh_arbiter_tb;
    localparam int CLK_NS = 10;
    localparam int ACC_NS = 55, CYC_NS = 100, REF_NS = 70, INT_NS = 400;
    localparam int ACC_C = (ACC_NS + CLK_NS - 1) / CLK_NS;   // 6
    localparam int CYC_C = (CYC_NS + CLK_NS - 1) / CLK_NS;   // 10
    localparam int REF_C = (REF_NS + CLK_NS - 1) / CLK_NS;   // 7
    localparam int INT_C = (INT_NS + CLK_NS - 1) / CLK_NS;   // 40

    logic clk = 1'b0, rst_n = 1'b0, host_req = 1'b0, host_we = 1'b0;
    logic busy, data_valid, arr_host, arr_we, ref_active;
    logic [3:0] ref_bank_en;
    logic [6:0] ref_row;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    dram_refresh_arbiter #(
        .CLK_PERIOD_NS(CLK_NS), .ACCESS_NS(ACC_NS), .CYCLE_NS(CYC_NS),
        .REFRESH_NS(REF_NS), .INTERVAL_NS(INT_NS), .ROW_W(7), .BANKS(4)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .busy(busy), .data_valid(data_valid), .arr_host(arr_host), .arr_we(arr_we),
        .ref_active(ref_active), .ref_bank_en(ref_bank_en), .ref_row(ref_row)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 refresh, 2 host access
    int m_tmr = 0, m_row = 0, m_ph = 0, m_left = 0, m_el = 0;
    bit m_refp = 0, m_hostp = 0, m_busy = 0, m_dv = 0, m_we = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_tmr = 0; m_row = 0; m_ph = 0; m_left = 0; m_el = 0;
            m_refp = 0; m_hostp = 0; m_busy = 0; m_dv = 0; m_we = 0;
        end else begin
            bit tick_now, take;
            tick_now = (m_tmr == INT_C - 1);
            take = host_req && !m_busy;
            m_tmr = tick_now ? 0 : m_tmr + 1;
            m_dv = 0;
            if (m_ph == 0) begin
                if (m_refp) begin m_ph = 1; m_left = REF_C; m_refp = 0; end
                else if (m_hostp) begin m_ph = 2; m_el = 0; m_hostp = 0; end
            end else if (m_ph == 1) begin
                if (m_left == 1) begin m_ph = 0; m_row = (m_row + 1) % 128; end
                else m_left--;
            end else begin
                if (m_el == ACC_C - 1 && !m_we) m_dv = 1;
                if (m_el == CYC_C - 1) begin m_ph = 0; m_busy = 0; end
                else m_el++;
            end
            if (tick_now) m_refp = 1;
            if (take) begin m_hostp = 1; m_busy = 1; m_we = host_we; end
        end
    end

    // per-cycle comparison against the model
    int n_falls = 0;
    bit prev_ref = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5", "busy", busy, m_busy);
            chk("R4", "data_valid", data_valid, m_dv);
            chk("R2", "ref_active", ref_active, m_ph == 1);
            chk("R2", "ref_bank_en", ref_bank_en, (m_ph == 1) ? 15 : 0);
            chk("R8", "arr_host", arr_host, m_ph == 2);
            chk("R8", "arr_we", arr_we, (m_ph == 2) && m_we);
            chk("R6", "ref_row", ref_row, m_row);
            if (prev_ref && !ref_active) n_falls++;
            prev_ref = ref_active;
        end
    end

    task automatic wait_quiet();
        do @(negedge clk);
        while (!(m_ph == 0 && !m_busy && !m_refp && m_tmr > 2 && m_tmr < INT_C - CYC_C - 6));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int e, lat, we_cnt, host_cnt;
        bit saw_dv, saw_ref_first;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "outputs in reset", {data_valid, arr_host, arr_we, ref_active}, 0);
        chk("R1", "ref_row in reset", ref_row, 0);
        chk("R1", "bank enables in reset", ref_bank_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "ref_active after reset", ref_active, 0);

        // R4/R5: uncontended read
        wait_quiet();
        host_req = 1; host_we = 0; e = cyc + 1;
        @(negedge clk); host_req = 0;
        chk("R3", "busy after accept", busy, 1);
        while (!data_valid && cyc < e + 40) @(negedge clk);
        chk("R4", "read latency", cyc - e, ACC_C + 1);
        @(negedge clk);
        chk("R4", "data_valid single cycle", data_valid, 0);
        while (busy && cyc < e + 40) @(negedge clk);
        chk("R5", "busy length", cyc - e, CYC_C + 1);

        // R3/R8: write, plus a request during busy that must be ignored
        wait_quiet();
        host_req = 1; host_we = 1; e = cyc + 1;
        @(negedge clk); host_req = 0; host_we = 0;
        saw_dv = 0; we_cnt = 0; host_cnt = 0;
        repeat (3) @(negedge clk);
        host_req = 1;                      // busy is high here
        @(negedge clk); host_req = 0;
        while (busy && cyc < e + 40) begin
            if (data_valid) saw_dv = 1;
            if (arr_we) we_cnt++;
            if (arr_host) host_cnt++;
            @(negedge clk);
        end
        chk("R4", "write gives no data_valid", saw_dv, 0);
        chk("R8", "arr_we cycles on write", we_cnt, CYC_C - 3);
        chk("R5", "write busy length", cyc - e, CYC_C + 1);
        repeat (4) begin
            chk("R3", "no access from ignored request", arr_host | busy, 0);
            @(negedge clk);
        end

        // R7: host request in the same cycle the refresh timer expires
        do @(negedge clk);
        while (!(m_tmr == INT_C - 1 && m_ph == 0 && !m_busy && !m_refp));
        host_req = 1; host_we = 0; e = cyc + 1;
        @(negedge clk); host_req = 0;
        @(negedge clk);
        saw_ref_first = ref_active && !arr_host;
        chk("R7", "refresh granted before host", saw_ref_first, 1);
        while (!data_valid && cyc < e + 60) @(negedge clk);
        chk("R7", "collided read latency", cyc - e, ACC_C + 1 + REF_C + 1);

        // R6: run past 128 refreshes to see the row wrap
        repeat (130 * INT_C) @(negedge clk);
        chk("R6", "refresh count reached wrap", n_falls >= 128, 1);
        chk("R6", "row after wrap", ref_row, n_falls % 128);
        chk("R2", "refresh rate", n_falls >= (cyc / INT_C) - 2, 1);

        done = 1;
        finish_run();
    end
endmodule